// File: doc/BRIEF.md
# Asynchronous Tag-Fault Status Register

This block keeps a 64-bit status word that collects tag-check faults raised by code running at the least privileged level and reported after the fact rather than at the faulting instruction. Two sticky flags sit in the lowest bits, one for each half of the virtual address space. The half is selected by bit 55 of the faulting address. Once a flag is set it stays set until software writes the register.

Software reaches the word through system-register read and write requests. Each request that carries the register's encoding goes through a permission check before it touches the flags. The check looks at the current privilege level and at the allocation-tag enable bits owned by levels 2 and 3, and gives one of three results: the access completes, it is undefined, or it traps to level 2 or level 3 with a syndrome class. The result is reported on registered outputs one cycle after the request. A parameter removes the whole fault-status feature. With the feature removed, every access is undefined and the flags are held at zero.

Top module: `async_tagflt_status`

## Requirements
- R1: The readable value is 64 bits wide. Bits 63:2 always read as zero, and write data in those bits has no effect.
- R2: A fault event whose address bit 55 is 1 sets flag bit 1. A fault event whose bit 55 is 0 sets flag bit 0. Flags stay set across later faults and reads.
- R3: A request is recognised only when its 16-bit encoding {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]} equals 0xC2B1 (op0=3, op1=0, CRn=5, CRm=6, op2=1). Any other encoding gets no response and changes no state.
- R4: A recognised read or write from level 0 (cur_el=0) is reported as undefined.
- R5: From level 1, a recognised access traps to level 2 (trap_el=2) with class 0x18 when level 2 is enabled, level-0 host mode is off and the level-2 tag enable is 0. This check is made before the level-3 check.
- R6: From level 1 (when R5 did not fire) or from level 2, a recognised access traps to level 3 (trap_el=3) with class 0x18 when level 3 is present and the level-3 tag enable is 0.
- R7: A recognised access from level 3 always completes, whatever the control bits are.
- R8: With PRESENT=0, every recognised access is undefined and returns zero read data.
- R9: When a fault event and a completed write fall in the same cycle, bits 1:0 take the write data OR'ed with the fault's bit, so the fault is never lost. A completed write on its own loads bits 1:0 from write data bits 1:0.
- R10: Reset clears both flags. An undefined or trapped access changes no flag and returns zero read data.
- R11: Exactly one of resp_ok, resp_undef and trap_valid pulses, in the cycle after each recognised request. A completed read returns the flags as they were before that request's clock edge. A completed write returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | A tag-check fault is reported this cycle |
| flt_va55 | input | 1 | Bit 55 of the faulting virtual address |
| req_valid | input | 1 | System-register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_enc | input | 16 | Packed access encoding {op0,op1,CRn,CRm,op2} |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level 0..3 |
| el2_enabled | input | 1 | Level 2 is enabled for the current state |
| el0_host | input | 1 | Level 0 runs in host mode |
| el2_tag_en | input | 1 | Allocation-tag enable owned by level 2 |
| el3_present | input | 1 | Level 3 is implemented |
| el3_tag_en | input | 1 | Allocation-tag enable owned by level 3 |
| resp_ok | output | 1 | Access completed |
| resp_undef | output | 1 | Access is undefined |
| trap_valid | output | 1 | Access trapped |
| trap_el | output | 2 | Trap target level (2 or 3) |
| trap_class | output | 6 | Trap syndrome class |
| rd_data | output | 64 | Read data |

## Verification
A fault report and a completed write can land on the same clock edge, and this is the one case where two sources update the flags together. The bench drives a level-3 write together with a fault on the same negative edge, using write data that would clear the fault's bit. It then reads back at level 3 and expects the written value OR'ed with the fault's bit. A second same-cycle case pairs a fault with a read and checks that the read returns the old flags while the next read shows the new bit.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [1:0] {
    OUT_OK    = 2'd0,
    OUT_UNDEF = 2'd1,
    OUT_TRAP  = 2'd2
  } outcome_e;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam int ENC_W = $bits(sysreg_enc_t);
  localparam sysreg_enc_t STATUS_ENC = '{op0: 2'd3, op1: 3'd0, crn: 4'd5, crm: 4'd6, op2: 3'd1};
  localparam logic [5:0] EC_SYSREG = 6'h18;
endpackage

// File: rtl/tfs_enc_match.sv
module tfs_enc_match
  import tfs_pkg::*;
(
  input  logic             req_valid,
  input  logic [ENC_W-1:0] req_enc,
  output logic             hit
);
  sysreg_enc_t enc;
  always_comb begin
    enc = sysreg_enc_t'(req_enc);
    hit = req_valid &&
          (enc.op0 == STATUS_ENC.op0) && (enc.op1 == STATUS_ENC.op1) &&
          (enc.crn == STATUS_ENC.crn) && (enc.crm == STATUS_ENC.crm) &&
          (enc.op2 == STATUS_ENC.op2);
  end
endmodule

// File: rtl/tfs_perm_chk.sv
module tfs_perm_chk
  import tfs_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic [1:0] cur_el,
  input  logic       el2_enabled,
  input  logic       el0_host,
  input  logic       el2_tag_en,
  input  logic       el3_present,
  input  logic       el3_tag_en,
  output outcome_e   outcome,
  output logic [1:0] target_el
);
  logic to_el2, to_el3;

  always_comb begin
    to_el2    = el2_enabled && !el0_host && !el2_tag_en;
    to_el3    = el3_present && !el3_tag_en;
    outcome   = OUT_OK;
    target_el = 2'd0;
    if (!PRESENT) begin
      outcome = OUT_UNDEF;
    end else begin
      unique case (cur_el)
        2'd0: outcome = OUT_UNDEF;
        2'd1: begin
          if (to_el2) begin
            outcome   = OUT_TRAP;
            target_el = 2'd2;
          end else if (to_el3) begin
            outcome   = OUT_TRAP;
            target_el = 2'd3;
          end
        end
        2'd2: begin
          if (to_el3) begin
            outcome   = OUT_TRAP;
            target_el = 2'd3;
          end
        end
        default: outcome = OUT_OK;
      endcase
    end
  end
endmodule

// File: rtl/tfs_flag_store.sv
module tfs_flag_store #(
  parameter bit PRESENT = 1'b1,
  parameter int FLAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic              flt_va55,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_flags,
  output logic [FLAG_W-1:0] flags
);
  generate
    if (PRESENT) begin : g_store
      for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        logic set_now;
        logic bit_q;
        assign set_now = flt_valid && (int'(flt_va55) == i);
        always_ff @(posedge clk) begin
          if (rst)        bit_q <= 1'b0;
          else if (wr_en) bit_q <= wr_flags[i] | set_now;
          else            bit_q <= bit_q | set_now;
        end
        assign flags[i] = bit_q;
      end
    end else begin : g_absent
      logic unused_absent;
      assign unused_absent = clk ^ rst ^ flt_valid ^ flt_va55 ^ wr_en ^ (^wr_flags);
      assign flags = '0;
    end
  endgenerate
endmodule

// File: rtl/async_tagflt_status.sv
module async_tagflt_status
  import tfs_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int EC_W    = 6,
  parameter bit PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic              flt_va55,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_enc,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_el,
  input  logic              el2_enabled,
  input  logic              el0_host,
  input  logic              el2_tag_en,
  input  logic              el3_present,
  input  logic              el3_tag_en,
  output logic              resp_ok,
  output logic              resp_undef,
  output logic              trap_valid,
  output logic [1:0]        trap_el,
  output logic [EC_W-1:0]   trap_class,
  output logic [DATA_W-1:0] rd_data
);
  localparam int FLAG_W = 2;

  logic              hit;
  outcome_e          outcome;
  logic [1:0]        target_el;
  logic              wr_en;
  logic [FLAG_W-1:0] flags_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^req_wdata[DATA_W-1:FLAG_W];

  tfs_enc_match u_match (
    .req_valid (req_valid),
    .req_enc   (req_enc),
    .hit       (hit)
  );

  tfs_perm_chk #(.PRESENT(PRESENT)) u_perm (
    .cur_el      (cur_el),
    .el2_enabled (el2_enabled),
    .el0_host    (el0_host),
    .el2_tag_en  (el2_tag_en),
    .el3_present (el3_present),
    .el3_tag_en  (el3_tag_en),
    .outcome     (outcome),
    .target_el   (target_el)
  );

  assign wr_en = hit && (outcome == OUT_OK) && req_write;

  tfs_flag_store #(.PRESENT(PRESENT), .FLAG_W(FLAG_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .flt_valid (flt_valid),
    .flt_va55  (flt_va55),
    .wr_en     (wr_en),
    .wr_flags  (req_wdata[FLAG_W-1:0]),
    .flags     (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_ok    <= 1'b0;
      resp_undef <= 1'b0;
      trap_valid <= 1'b0;
      trap_el    <= 2'd0;
      trap_class <= '0;
      rd_data    <= '0;
    end else begin
      resp_ok    <= hit && (outcome == OUT_OK);
      resp_undef <= hit && (outcome == OUT_UNDEF);
      trap_valid <= hit && (outcome == OUT_TRAP);
      trap_el    <= (hit && outcome == OUT_TRAP) ? target_el : 2'd0;
      trap_class <= (hit && outcome == OUT_TRAP) ? EC_W'(EC_SYSREG) : '0;
      rd_data    <= (hit && outcome == OUT_OK && !req_write)
                    ? {{(DATA_W-FLAG_W){1'b0}}, flags_q} : '0;
    end
  end
endmodule

// File: rtl/async_tagflt_status_chk.sv
module async_tagflt_status_chk
  import tfs_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int EC_W    = 6,
  parameter bit PRESENT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              flt_valid,
  input logic              flt_va55,
  input logic              req_valid,
  input logic [15:0]       req_enc,
  input logic [1:0]        cur_el,
  input logic              resp_ok,
  input logic              resp_undef,
  input logic              trap_valid,
  input logic [1:0]        trap_el,
  input logic [EC_W-1:0]   trap_class,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        flags_q
);
  logic enc_ok;
  assign enc_ok = req_valid && (req_enc == 16'hC2B1);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_ok, resp_undef, trap_valid})); // R11
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:2] == '0); // R1
  AST_NO_REQ_SILENT: assert property (@(posedge clk) disable iff (rst)
    !enc_ok |=> !(resp_ok || resp_undef || trap_valid)); // R3
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd0) |=> resp_undef); // R4
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> (trap_class == EC_W'(6'h18) && trap_el[1])); // R5
  AST_EL3_DONE: assert property (@(posedge clk) disable iff (rst)
    (PRESENT && enc_ok && cur_el == 2'd3) |=> resp_ok); // R7
  AST_ABSENT_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (!PRESENT && enc_ok) |=> resp_undef); // R8
  AST_FAULT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (PRESENT && flt_valid) |=> flags_q[$past(flt_va55)]); // R9
  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (resp_undef || trap_valid) |-> rd_data == '0); // R10
endmodule

bind async_tagflt_status async_tagflt_status_chk #(
  .DATA_W(DATA_W), .EC_W(EC_W), .PRESENT(PRESENT)
) chk_i (
  .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_va55(flt_va55),
  .req_valid(req_valid), .req_enc(req_enc), .cur_el(cur_el),
  .resp_ok(resp_ok), .resp_undef(resp_undef), .trap_valid(trap_valid),
  .trap_el(trap_el), .trap_class(trap_class), .rd_data(rd_data),
  .flags_q(flags_q)
);

// File: tb/async_tagflt_status_tb_top.sv
`timescale 1ns/1ps
module async_tagflt_status_tb_top;
  localparam logic [15:0] ENC = 16'hC2B1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_valid = 0, flt_va55 = 0, req_valid = 0, req_write = 0;
  logic [15:0] req_enc = ENC;
  logic [63:0] req_wdata = '0;
  logic [1:0]  cur_el = 2'd3;
  logic el2_enabled = 0, el0_host = 0, el2_tag_en = 0, el3_present = 0, el3_tag_en = 0;

  logic ok, undef, trp;
  logic [1:0] tel;
  logic [5:0] tcls;
  logic [63:0] rd;
  logic ok_n, undef_n, trp_n;
  logic [1:0] tel_n;
  logic [5:0] tcls_n;
  logic [63:0] rd_n;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  async_tagflt_status dut_i (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_va55(flt_va55),
    .req_valid(req_valid), .req_write(req_write), .req_enc(req_enc),
    .req_wdata(req_wdata), .cur_el(cur_el), .el2_enabled(el2_enabled),
    .el0_host(el0_host), .el2_tag_en(el2_tag_en), .el3_present(el3_present),
    .el3_tag_en(el3_tag_en), .resp_ok(ok), .resp_undef(undef),
    .trap_valid(trp), .trap_el(tel), .trap_class(tcls), .rd_data(rd));

  async_tagflt_status #(.PRESENT(1'b0)) dut_off_i (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_va55(flt_va55),
    .req_valid(req_valid), .req_write(req_write), .req_enc(req_enc),
    .req_wdata(req_wdata), .cur_el(cur_el), .el2_enabled(el2_enabled),
    .el0_host(el0_host), .el2_tag_en(el2_tag_en), .el3_present(el3_present),
    .el3_tag_en(el3_tag_en), .resp_ok(ok_n), .resp_undef(undef_n),
    .trap_valid(trp_n), .trap_el(tel_n), .trap_class(tcls_n), .rd_data(rd_n));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outcome code: 0 ok, 1 undef, 2 trap; also returns target level
  function automatic int model(int el, bit e2en, bit host, bit e2tag, bit e3p, bit e3tag,
                               output int tgt);
    tgt = 0;
    if (el == 0) return 1;
    if (el == 3) return 0;
    if (el == 1 && e2en && !host && !e2tag) begin tgt = 2; return 2; end
    if (e3p && !e3tag) begin tgt = 3; return 2; end
    return 0;
  endfunction

  // drive one request on a negedge; sample on the following negedge
  task automatic access(int el, bit wr, logic [63:0] wd, logic [15:0] enc);
    cur_el = 2'(el); req_write = wr; req_wdata = wd; req_enc = enc; req_valid = 1;
    @(negedge clk);
    req_valid = 0; flt_valid = 0;
  endtask

  task automatic el3_read(output logic [1:0] f);
    access(3, 0, '0, ENC);
    f = rd[1:0];
  endtask

  task automatic el3_write(logic [63:0] wd);
    access(3, 1, wd, ENC);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] f;
    int tgt, exp_o;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 reset ok", {63'b0, ok}, 64'd0);
    check("R10 reset rd", rd, 64'd0);
    el3_read(f);
    check("R10 flags after reset", {62'b0, f}, 64'd0);
    check("R11 read completes", {63'b0, ok}, 64'd1);

    // R2 faults, sticky
    flt_valid = 1; flt_va55 = 0; @(negedge clk); flt_valid = 0;
    el3_read(f);
    check("R2 va55=0 sets bit0", {62'b0, f}, 64'd1);
    flt_valid = 1; flt_va55 = 1; @(negedge clk); flt_valid = 0;
    el3_read(f);
    check("R2 va55=1 sets bit1", {62'b0, f}, 64'd3);
    el3_read(f);
    check("R2 sticky across read", {62'b0, f}, 64'd3);

    // R1 high bits ignored, R11 write returns zero data
    el3_write(64'hFFFF_FFFF_FFFF_FFFE);
    check("R11 write rd zero", rd, 64'd0);
    access(3, 0, '0, ENC);
    check("R1 high bits read zero", rd, 64'd2);

    // R3 wrong encodings: no response, no state change
    for (int b = 0; b < 16; b++) begin
      access(3, 1, 64'd0, ENC ^ (16'd1 << b));
      check("R3 no response", {61'b0, ok, undef, trp}, 64'd0);
    end
    el3_read(f);
    check("R3 state unchanged", {62'b0, f}, 64'd2);

    // R9 fault and write in the same cycle
    flt_valid = 1; flt_va55 = 1;
    el3_write(64'd0);
    el3_read(f);
    check("R9 fault wins bit1", {62'b0, f}, 64'd2);
    flt_valid = 1; flt_va55 = 0;
    el3_write(64'd2);
    el3_read(f);
    check("R9 fault merges bit0", {62'b0, f}, 64'd3);
    el3_write(64'd0);
    flt_valid = 1; flt_va55 = 0;
    access(3, 0, '0, ENC);
    check("R11 read sees pre-edge flags", rd, 64'd0);
    el3_read(f);
    check("R2 fault during read kept", {62'b0, f}, 64'd1);

    // R4..R7, R10 sweep over all levels and control combinations
    for (int el = 0; el < 4; el++) begin
      for (int c = 0; c < 32; c++) begin
        for (int wr = 0; wr < 2; wr++) begin
          logic [1:0] seed;
          seed = 2'(c + el);
          el3_write({62'b0, seed});
          el2_enabled = c[0]; el0_host = c[1]; el2_tag_en = c[2];
          el3_present = c[3]; el3_tag_en = c[4];
          exp_o = model(el, c[0], c[1], c[2], c[3], c[4], tgt);
          access(el, wr[0], {62'h3FFF_FFFF_FFFF_FFFF, ~seed}, ENC);
          check(el == 0 ? "R4 undef" : (el == 3 ? "R7 completes" :
                (tgt == 2 ? "R5 trap el2" : "R6 trap el3")),
                {61'b0, ok, undef, trp}, exp_o == 0 ? 64'd4 : (exp_o == 1 ? 64'd2 : 64'd1));
          check(tgt == 2 ? "R5 target/class" : "R6 target/class",
                {56'b0, tel, tcls}, exp_o == 2 ? {56'b0, 2'(tgt), 6'h18} : 64'd0);
          check("R11 read data", rd,
                (exp_o == 0 && wr == 0) ? {62'b0, seed} : 64'd0);
          el2_enabled = 0; el0_host = 0; el2_tag_en = 0; el3_present = 0; el3_tag_en = 0;
          el3_read(f);
          check("R10 state after access", {62'b0, f},
                (exp_o == 0 && wr == 1) ? {62'b0, ~seed} : {62'b0, seed});
        end
      end
    end

    // R8 feature absent
    for (int el = 0; el < 4; el++) begin
      flt_valid = 1; flt_va55 = el[0];
      access(el, el[1], 64'hF, ENC);
      check("R8 absent undef", {61'b0, ok_n, undef_n, trp_n}, 64'd2);
      access(el, 0, 64'd0, ENC);
      check("R8 absent rd zero", rd_n, 64'd0);
    end

    // R10 reset clears set flags
    el3_write(64'd3);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    el3_read(f);
    check("R10 reset clears", {62'b0, f}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule